// File: doc/BRIEF.md
# Hashed Load/Store Queue Clash Detector

This block keeps a small table of in-flight memory operations and reports which of them may touch the same memory. It does not compare full addresses. Each operation is reduced to a 16-bit tag when it is written into the table, and the tag is stored with the entry. Every pair of occupied entries is then checked by a narrow equality comparator on the stored tags. The tag is built by XOR-folding the 64-bit virtual address down to 16 bits. Ten translated page-number bits (address bits 21 to 12) are then XORed into the low end of the tag. This scatters accesses that sit on large, regular virtual strides.

Up to four operations can be offered in each cycle, one per lane. Each accepted operation takes the lowest-numbered free entry, with lanes served in index order. A lane that finds no entry left is refused through its ready output. Entries are released one by one through a clear input. The result is a registered, symmetric clash matrix in which only pairs that include at least one store count. A per-entry conflict flag is derived from it. The surrounding scheduler uses these flags to hold back operations that might alias.

Top module: `lsq_clash_detect`

## Requirements
- R1: After reset every entry is free, `clash_o` and `conflict_o` are all zero, and all four bits of `enq_ready` are 1.
- R2: The tag of an operation equals `va[15:0] ^ va[31:16] ^ va[47:32] ^ va[63:48]`, with the 10 physical bits XORed into tag bits 9:0. Two operations whose tags are equal are treated as matching even if their addresses differ.
- R3: In one cycle, accepted lanes are placed in ascending lane order into the free entries in ascending entry order. A lane whose `enq_valid` is 0 consumes no entry.
- R4: `enq_ready[l]` is 1 exactly when the number of free entries is greater than the number of lanes below `l` that have `enq_valid` set. A lane that is valid but not ready writes nothing into the table.
- R5: Bit `i*8+j` of `clash_o` is 1 only when `i` is not equal to `j`, both entries are occupied, at least one of them is a store, and their tags are equal. A pair of two loads never clashes.
- R6: Tags that differ in any single bit produce no clash.
- R7: `clash_o` is symmetric: bit `i*8+j` always equals bit `j*8+i`. Every diagonal bit `i*8+i` is 0.
- R8: `clash_o` is a register. It shows the table contents that result from the enqueues and clears applied at the previous rising clock edge.
- R9: `conflict_o[i]` is the OR of bits `i*8` through `i*8+7` of `clash_o`.
- R10: Raising `clr[i]` frees entry `i` at the next edge, and the entry drops out of `clash_o` in the same update. An entry being cleared does not count as free for enqueues in that same cycle. It can be reused from the next cycle on.
- R11: Raising `clr[i]` for an entry that is already free changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enq_valid | input | 4 | Per-lane request to add an operation |
| enq_store | input | 4 | Per-lane kind: 1 = store, 0 = load |
| enq_vaddr | input | 256 | Per-lane virtual address, lane l in bits l*64 +: 64 |
| enq_pbits | input | 40 | Per-lane physical bits 21:12, lane l in bits l*10 +: 10 |
| enq_ready | output | 4 | Per-lane acceptance, combinational from state and enq_valid |
| clr | input | 8 | Per-entry release |
| clash_o | output | 64 | Registered pair matrix, bit i*8+j for entries i and j |
| conflict_o | output | 8 | Per-entry OR of its matrix row |

## Verification
The bench builds tags that collide on purpose. One collision comes from folding two virtual-address chunks together, and another comes from physical bits cancelling a virtual-address bit. A detector that compared raw addresses, or dropped the physical bits, would miss these clashes. The bench also sends load-only pairs and tag pairs that differ by a single bit, to catch a design that reports false clashes or ignores the load/store kind. Allocation is exercised with holes in the table, with invalid lanes mixed between valid ones, and with more requests than free entries. Any off-by-one in the readiness count, or a refused lane that still writes, would then place entries wrongly and show up in the matrix. Clearing an entry in the same cycle as an enqueue is also tested: a design that reused that entry at once would accept a request that should be refused.

// File: rtl/lsq_clash_pkg.sv
package lsq_clash_pkg;
    parameter int unsigned NUM_SLOTS = 8;
    parameter int unsigned NUM_LANES = 4;
    parameter int unsigned VA_W      = 64;
    parameter int unsigned PB_W      = 10;
    parameter int unsigned HASH_W    = 16;

    localparam int unsigned IDX_W     = $clog2(NUM_SLOTS);
    localparam int unsigned NUM_PAIRS = NUM_SLOTS * (NUM_SLOTS - 1) / 2;
    localparam int unsigned MAT_W     = NUM_SLOTS * NUM_SLOTS;

    typedef logic [HASH_W-1:0] tag_t;

    typedef struct packed {
        logic busy;
        logic is_st;
        tag_t tag;
    } slot_t;

    typedef struct packed {
        slot_t [NUM_SLOTS-1:0] slots;
        logic  [MAT_W-1:0]     clash;
    } core_t;

    // Flat index of the unordered pair (i, j), i < j
    function automatic int unsigned pair_index(input int unsigned i, input int unsigned j);
        return i * NUM_SLOTS - (i * (i + 1)) / 2 + (j - i - 1);
    endfunction
endpackage

// File: rtl/addr_fold_hash.sv
module addr_fold_hash #(
    parameter int unsigned VA_W   = 64,
    parameter int unsigned PB_W   = 10,
    parameter int unsigned HASH_W = 16
) (
    input  logic [VA_W-1:0]   vaddr,
    input  logic [PB_W-1:0]   pbits,
    output logic [HASH_W-1:0] tag
);
    localparam int unsigned CHUNKS = (VA_W + HASH_W - 1) / HASH_W;
    localparam int unsigned PAD_W  = CHUNKS * HASH_W;

    logic [PAD_W-1:0]  va_pad;
    logic [HASH_W-1:0] fold;

    always_comb begin
        va_pad = '0;
        va_pad[VA_W-1:0] = vaddr;
        fold = '0;
        for (int c = 0; c < int'(CHUNKS); c++) begin
            fold = fold ^ va_pad[c*HASH_W +: HASH_W];
        end
        // Translated page bits land on the low end of the tag
        fold[PB_W-1:0] = fold[PB_W-1:0] ^ pbits;
    end

    assign tag = fold;
endmodule

// File: rtl/tag_eq_cmp.sv
module tag_eq_cmp #(
    parameter int unsigned HASH_W = 16
) (
    input  logic [HASH_W-1:0] a,
    input  logic [HASH_W-1:0] b,
    output logic              eq
);
    localparam int unsigned GROUPS = (HASH_W + 3) / 4;

    logic [GROUPS*4-1:0] diff;
    logic [GROUPS-1:0]   grp_diff;

    always_comb begin
        diff = '0;
        diff[HASH_W-1:0] = a ^ b;
    end

    // First level: a 4-input NAND over the inverted differences of each group
    for (genvar g = 0; g < int'(GROUPS); g++) begin : g_nand
        assign grp_diff[g] = ~&(~diff[g*4 +: 4]);
    end

    // Second level: NOR over the group results
    assign eq = ~|grp_diff;
endmodule

// File: rtl/slot_alloc.sv
module slot_alloc #(
    parameter int unsigned NUM_SLOTS = 8,
    parameter int unsigned NUM_LANES = 4,
    parameter int unsigned IDX_W     = 3
) (
    input  logic [NUM_SLOTS-1:0]       busy,
    input  logic [NUM_LANES-1:0]       req,
    output logic [NUM_LANES-1:0]       ready,
    output logic [NUM_LANES-1:0]       grant,
    output logic [NUM_LANES*IDX_W-1:0] slot_idx
);
    logic [NUM_SLOTS-1:0] taken;
    logic [IDX_W-1:0]     pick;
    logic                 avail;

    always_comb begin
        taken    = busy;
        ready    = '0;
        grant    = '0;
        slot_idx = '0;
        for (int l = 0; l < int'(NUM_LANES); l++) begin
            avail = ~&taken;
            pick  = '0;
            for (int s = int'(NUM_SLOTS) - 1; s >= 0; s--) begin
                if (!taken[s]) begin
                    pick = IDX_W'(s);
                end
            end
            ready[l] = avail;
            if (req[l] && avail) begin
                grant[l] = 1'b1;
                slot_idx[l*IDX_W +: IDX_W] = pick;
                taken[pick] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/lsq_clash_detect.sv
module lsq_clash_detect
    import lsq_clash_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_LANES-1:0]        enq_valid,
    input  logic [NUM_LANES-1:0]        enq_store,
    input  logic [NUM_LANES*VA_W-1:0]   enq_vaddr,
    input  logic [NUM_LANES*PB_W-1:0]   enq_pbits,
    output logic [NUM_LANES-1:0]        enq_ready,
    input  logic [NUM_SLOTS-1:0]        clr,
    output logic [MAT_W-1:0]            clash_o,
    output logic [NUM_SLOTS-1:0]        conflict_o
);
    core_t st_q, st_d;

    slot_t [NUM_SLOTS-1:0]       slots_nx;
    logic  [NUM_SLOTS-1:0]       busy_q;
    logic  [NUM_SLOTS-1:0]       store_q;
    logic  [NUM_LANES-1:0]       grant;
    logic  [NUM_LANES*IDX_W-1:0] grant_idx;
    tag_t  [NUM_LANES-1:0]       lane_tag;
    logic  [NUM_PAIRS-1:0]       pair_eq;

    always_comb begin
        for (int s = 0; s < int'(NUM_SLOTS); s++) begin
            busy_q[s]  = st_q.slots[s].busy;
            store_q[s] = st_q.slots[s].is_st;
        end
    end

    // One tag generator per enqueue lane
    for (genvar l = 0; l < int'(NUM_LANES); l++) begin : g_hash
        addr_fold_hash #(
            .VA_W   (VA_W),
            .PB_W   (PB_W),
            .HASH_W (HASH_W)
        ) u_hash (
            .vaddr (enq_vaddr[l*VA_W +: VA_W]),
            .pbits (enq_pbits[l*PB_W +: PB_W]),
            .tag   (lane_tag[l])
        );
    end

    slot_alloc #(
        .NUM_SLOTS (NUM_SLOTS),
        .NUM_LANES (NUM_LANES),
        .IDX_W     (IDX_W)
    ) u_alloc (
        .busy     (busy_q),
        .req      (enq_valid),
        .ready    (enq_ready),
        .grant    (grant),
        .slot_idx (grant_idx)
    );

    // Next table contents: clears first, then grants (never to a cleared slot)
    always_comb begin
        slots_nx = st_q.slots;
        for (int s = 0; s < int'(NUM_SLOTS); s++) begin
            if (clr[s]) begin
                slots_nx[s].busy = 1'b0;
            end
        end
        for (int l = 0; l < int'(NUM_LANES); l++) begin
            if (grant[l]) begin
                slots_nx[grant_idx[l*IDX_W +: IDX_W]].busy  = 1'b1;
                slots_nx[grant_idx[l*IDX_W +: IDX_W]].is_st = enq_store[l];
                slots_nx[grant_idx[l*IDX_W +: IDX_W]].tag   = lane_tag[l];
            end
        end
    end

    // One narrow comparator per unordered pair
    for (genvar i = 0; i < int'(NUM_SLOTS); i++) begin : g_row
        for (genvar j = i + 1; j < int'(NUM_SLOTS); j++) begin : g_col
            tag_eq_cmp #(
                .HASH_W (HASH_W)
            ) u_cmp (
                .a  (slots_nx[i].tag),
                .b  (slots_nx[j].tag),
                .eq (pair_eq[pair_index(i, j)])
            );
        end
    end

    always_comb begin
        logic hit;
        st_d.slots = slots_nx;
        st_d.clash = '0;
        for (int i = 0; i < int'(NUM_SLOTS); i++) begin
            for (int j = i + 1; j < int'(NUM_SLOTS); j++) begin
                hit = slots_nx[i].busy && slots_nx[j].busy &&
                      (slots_nx[i].is_st || slots_nx[j].is_st) &&
                      pair_eq[pair_index(i, j)];
                st_d.clash[i*NUM_SLOTS + j] = hit;
                st_d.clash[j*NUM_SLOTS + i] = hit;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign clash_o = st_q.clash;

    always_comb begin
        for (int i = 0; i < int'(NUM_SLOTS); i++) begin
            conflict_o[i] = |st_q.clash[i*NUM_SLOTS +: NUM_SLOTS];
        end
    end
endmodule

// File: rtl/lsq_clash_checker.sv
module lsq_clash_checker
    import lsq_clash_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LANES-1:0] enq_valid,
    input logic [NUM_LANES-1:0] enq_ready,
    input logic [NUM_SLOTS-1:0] clr,
    input logic [MAT_W-1:0]     clash_o,
    input logic [NUM_SLOTS-1:0] conflict_o,
    input logic [NUM_SLOTS-1:0] busy_q,
    input logic [NUM_SLOTS-1:0] store_q
);
    // R1
    reset_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (clash_o == '0) && (enq_ready == '1));

    for (genvar l = 1; l < int'(NUM_LANES); l++) begin : g_lane
        // R4
        ready_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
            enq_ready[l] |-> enq_ready[l-1]);
    end

    for (genvar i = 0; i < int'(NUM_SLOTS); i++) begin : g_i
        // R7
        diag_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !clash_o[i*NUM_SLOTS + i]);

        // R10
        clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            clr[i] |=> !busy_q[i] && !conflict_o[i]);

        // R5
        conflict_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
            conflict_o[i] |-> busy_q[i]);

        for (genvar j = 0; j < int'(NUM_SLOTS); j++) begin : g_j
            // R7
            symmetric_chk: assert property (@(posedge clk) disable iff (!rst_n)
                clash_o[i*NUM_SLOTS + j] == clash_o[j*NUM_SLOTS + i]);

            // R5
            store_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
                clash_o[i*NUM_SLOTS + j] |->
                    busy_q[i] && busy_q[j] && (store_q[i] || store_q[j]));
        end
    end
endmodule

bind lsq_clash_detect lsq_clash_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enq_valid  (enq_valid),
    .enq_ready  (enq_ready),
    .clr        (clr),
    .clash_o    (clash_o),
    .conflict_o (conflict_o),
    .busy_q     (busy_q),
    .store_q    (store_q)
);

// File: tb/lsq_clash_detect_test.sv
module lsq_clash_detect_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   enq_valid = '0;
    logic [3:0]   enq_store = '0;
    logic [255:0] enq_vaddr = '0;
    logic [39:0]  enq_pbits = '0;
    logic [3:0]   enq_ready;
    logic [7:0]   clr = '0;
    logic [63:0]  clash_o;
    logic [7:0]   conflict_o;

    int total = 0;
    int bad = 0;

    bit         m_busy [8];
    bit         m_st   [8];
    logic [15:0] m_tag [8];

    always #5 clk = ~clk;

    lsq_clash_detect uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .enq_valid  (enq_valid),
        .enq_store  (enq_store),
        .enq_vaddr  (enq_vaddr),
        .enq_pbits  (enq_pbits),
        .enq_ready  (enq_ready),
        .clr        (clr),
        .clash_o    (clash_o),
        .conflict_o (conflict_o)
    );

    function automatic logic [15:0] mk_tag(input logic [63:0] va, input logic [9:0] pb);
        logic [15:0] h;
        h = va[15:0] ^ va[31:16] ^ va[47:32] ^ va[63:48];
        h[9:0] = h[9:0] ^ pb;
        return h;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic verify_state(input string req);
        logic [63:0] em;
        logic [7:0]  ec;
        em = '0;
        ec = '0;
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                if (i != j && m_busy[i] && m_busy[j] && (m_st[i] || m_st[j]) &&
                    m_tag[i] == m_tag[j]) begin
                    em[i*8 + j] = 1'b1;
                    ec[i] = 1'b1;
                end
            end
        end
        check(clash_o === em, req, "clash matrix", clash_o, em);
        check(conflict_o === ec, req, "conflict flags (R9)", {56'd0, conflict_o}, {56'd0, ec});
    endtask

    // One cycle of stimulus; checks readiness before the edge, updates the model after it
    task automatic step(input logic [3:0] v, input logic [3:0] st,
                        input logic [255:0] va, input logic [39:0] pb,
                        input logic [7:0] cl, input string req);
        logic [3:0] er;
        int         gslot [4];
        int         nfree;
        int         cnt;
        bit         taken [8];
        @(negedge clk);
        enq_valid = v;
        enq_store = st;
        enq_vaddr = va;
        enq_pbits = pb;
        clr       = cl;
        #1;
        nfree = 0;
        for (int s = 0; s < 8; s++) begin
            taken[s] = m_busy[s];
            if (!m_busy[s]) nfree++;
        end
        cnt = 0;
        for (int l = 0; l < 4; l++) begin
            er[l] = (nfree > cnt);
            gslot[l] = -1;
            if (v[l] && er[l]) begin
                for (int s = 7; s >= 0; s--) begin
                    if (!taken[s]) gslot[l] = s;
                end
                taken[gslot[l]] = 1'b1;
                cnt++;
            end
        end
        check(enq_ready === er, req, "enq_ready", {60'd0, enq_ready}, {60'd0, er});
        @(posedge clk);
        #1;
        for (int s = 0; s < 8; s++) begin
            if (cl[s]) m_busy[s] = 1'b0;
        end
        for (int l = 0; l < 4; l++) begin
            if (gslot[l] >= 0) begin
                m_busy[gslot[l]] = 1'b1;
                m_st[gslot[l]]   = st[l];
                m_tag[gslot[l]]  = mk_tag(va[l*64 +: 64], pb[l*10 +: 10]);
            end
        end
        enq_valid = '0;
        clr       = '0;
    endtask

    task automatic idle_check(input string req);
        @(negedge clk);
        verify_state(req);
    endtask

    task automatic flush();
        step(4'b0, 4'b0, '0, '0, 8'hFF, "R10");
        idle_check("R10");
    endtask

    // R1: reset state
    task automatic t_reset();
        @(negedge clk);
        check(clash_o === '0, "R1", "clash after reset", clash_o, '0);
        check(conflict_o === '0, "R1", "conflict after reset", {56'd0, conflict_o}, '0);
        check(enq_ready === 4'hF, "R1", "ready after reset", {60'd0, enq_ready}, 64'hF);
    endtask

    // R5, R8: store/load and store/store clash; loads only do not
    task automatic t_kinds();
        logic [63:0] a;
        a = 64'h1234_5678_9ABC_DEF0;
        step(4'b0011, 4'b0001, {128'd0, a, a}, '0, '0, "R8");
        idle_check("R5 R8 store-load");
        check(clash_o[0*8+1] === 1'b1, "R8", "pair 0-1 visible after edge", {63'd0, clash_o[1]}, 64'd1);
        flush();
        step(4'b0011, 4'b0000, {128'd0, a, a}, '0, '0, "R5");
        idle_check("R5 load-load");
        check(clash_o === '0, "R5", "two loads never clash", clash_o, '0);
        flush();
        step(4'b1111, 4'b1111, {a, a, a, a}, '0, '0, "R5");
        idle_check("R5 four stores");
        check(conflict_o === 8'h0F, "R9", "row OR of four stores", {56'd0, conflict_o}, 64'h0F);
        flush();
    endtask

    // R2, R6: tag aliasing and single-bit differences
    task automatic t_tags();
        step(4'b0011, 4'b0001, {128'd0, 64'h0000_0000_0001_0001, 64'd0}, '0, '0, "R2");
        idle_check("R2 folded alias");
        check(clash_o[1] === 1'b1, "R2", "folded chunks alias", {63'd0, clash_o[1]}, 64'd1);
        flush();
        step(4'b0011, 4'b0001, {128'd0, 64'h4, 64'd0}, {20'd0, 10'd4, 10'd0}, '0, "R2");
        idle_check("R2 physical cancels virtual");
        check(clash_o[1] === 1'b1, "R2", "physical cancels virtual", {63'd0, clash_o[1]}, 64'd1);
        flush();
        step(4'b0011, 4'b0011, {128'd0, 64'h20_0000_0000 ^ 64'h55, 64'h55}, '0, '0, "R6");
        idle_check("R6 one va bit");
        check(clash_o === '0, "R6", "one tag bit apart", clash_o, '0);
        flush();
        step(4'b0011, 4'b0011, {128'd0, 64'h77, 64'h77}, {20'd0, 10'h200, 10'd0}, '0, "R6");
        idle_check("R6 one phys bit");
        check(clash_o === '0, "R6", "physical bit 9 apart", clash_o, '0);
        flush();
    endtask

    // R3, R4: filling, refusal, holes and invalid lanes
    task automatic t_alloc();
        step(4'b1111, 4'b0101, {64'h40, 64'h30, 64'h20, 64'h10}, '0, '0, "R3");
        step(4'b1111, 4'b1010, {64'h10, 64'h30, 64'h80, 64'h70}, '0, '0, "R3");
        idle_check("R3 full table");
        step(4'b1111, 4'b1111, {64'h10, 64'h10, 64'h10, 64'h10}, '0, '0, "R4 full");
        idle_check("R4 refused lanes write nothing");
        step(4'b0, 4'b0, '0, '0, 8'b0010_0010, "R10");
        idle_check("R10 holes");
        step(4'b1010, 4'b1010, {64'h30, 64'h99, 64'h40, 64'h99}, '0, '0, "R3 gaps");
        idle_check("R3 gap placement");
        step(4'b0, 4'b0, '0, '0, 8'b0000_0110, "R10");
        step(4'b1111, 4'b1111, {64'h70, 64'h20, 64'h40, 64'h10}, '0, '0, "R4 partial");
        idle_check("R4 partial accept");
        flush();
    endtask

    // R10, R11: same-cycle clear and clear of a free entry
    task automatic t_clear();
        step(4'b1111, 4'b0000, {64'h4, 64'h3, 64'h2, 64'h1}, '0, '0, "R10");
        step(4'b1111, 4'b0000, {64'h8, 64'h7, 64'h6, 64'h5}, '0, '0, "R10");
        step(4'b0001, 4'b0001, {192'd0, 64'h3}, '0, 8'b0000_1000, "R10 same cycle");
        idle_check("R10 cleared not reused same cycle");
        step(4'b0001, 4'b0001, {192'd0, 64'h2}, '0, '0, "R10 reuse");
        idle_check("R10 reuse next cycle");
        check(conflict_o === 8'b0000_1010, "R10", "reused entry clashes", {56'd0, conflict_o}, 64'b1010);
        step(4'b0, 4'b0, '0, '0, 8'b0000_0010, "R11");
        step(4'b0, 4'b0, '0, '0, 8'b0000_0010, "R11");
        idle_check("R11 clear of free entry");
        check(clash_o === '0, "R11", "second clear harmless", clash_o, '0);
        flush();
    endtask

    initial begin
        for (int s = 0; s < 8; s++) begin
            m_busy[s] = 1'b0;
            m_st[s]   = 1'b0;
            m_tag[s]  = '0;
        end
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        t_reset();
        t_kinds();
        t_tags();
        t_alloc();
        t_clear();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule